// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block arbitrates atomic read-modify-write sequences for several hardware thread contexts that share one physical memory. Each context may hold one reservation: a locked load opens it, and a later conditional store consumes it. The store succeeds only if no store to the same 16-byte block has landed in between, from any context. The monitor accepts at most one memory request per cycle. One cycle later it returns the outcome of a conditional store and a write-permit strobe that gates the memory write.

Each context also counts how many conditional stores in a row it has lost. Every time that count reaches a multiple of a parameterised interval, the block raises a one-cycle warning together with the context index, so that software or a debug unit can detect a thread that is starving. Uncacheable conditional stores bypass the reservation check and always succeed.

Top module: `resv_monitor`

## Requirements
- R1: A locked load (kind code 1) from context c stores the request address as c's reservation and sets c's reservation flag.
- R2: A conditional store (kind code 3) succeeds when its context's flag is set and the stored address and the store address are equal once bits [3:0] of both are ignored.
- R3: A conditional store whose context flag is clear fails.
- R4: A cacheable conditional store to a different 16-byte block fails. On any failure the issuer's flag is cleared and `wr_permit` stays 0.
- R5: Each failure adds one to the issuer's consecutive-failure count. When that count reaches a nonzero multiple of `WARN_EVERY`, `warn_pulse` is 1 for one cycle and `warn_ctx` gives the context.
- R6: A successful conditional store resets its context's failure count to zero.
- R7: A conditional store with `req_uncached`=1 always succeeds, does not look at the reservation, and resets the failure count.
- R8: A plain store (kind code 2) or a successful conditional store clears the flag of every context whose reservation lies in the same 16-byte block as the store, including the issuer.
- R9: `wr_permit` is 1 for a plain store and for a successful conditional store, and 0 for all loads. `sc_done` is 1 only for conditional stores.
- R10: A plain load (kind code 0) neither reads nor changes any reservation state.
- R11: Reset clears all flags, reservation addresses, failure counts and outputs.
- R12: `sc_done`, `sc_success`, `wr_permit`, `warn_pulse` and `warn_ctx` are registered. They appear on the first clock edge after the request is accepted and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctx | input | CTX_W | Index of the issuing context |
| req_kind | input | 2 | 0 plain load, 1 locked load, 2 plain store, 3 conditional store |
| req_uncached | input | 1 | Request targets uncacheable space |
| req_addr | input | ADDR_W | Physical address |
| sc_done | output | 1 | A conditional store result is presented |
| sc_success | output | 1 | Result of that conditional store |
| wr_permit | output | 1 | Memory may commit the write |
| warn_pulse | output | 1 | Failure-interval warning |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
The warning and a failed conditional-store result are produced in the same cycle, because the failure that completes an interval is what raises the warning. The bench uses a short interval and drives one context through failures caused in different ways: a clear flag, a block mismatch, and a reservation killed by another context. On the third failure it expects `warn_pulse`, the correct `warn_ctx`, `sc_done` high and `sc_success` low all on the same output cycle. A success or an uncacheable store placed in the middle must restart the interval, and the bench checks that the warning then does not come early.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      K_LOAD       = 2'd0,
      K_LOCK_LOAD  = 2'd1,
      K_STORE      = 2'd2,
      K_COND_STORE = 2'd3
   } req_kind_e;
endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
   parameter int ADDR_W  = 32,
   parameter int BLK_LSB = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      set_en,
   input  logic                      fail_clr,
   input  logic                      kill_en,
   input  logic [ADDR_W-1:BLK_LSB]   cmp_blk,
   output logic                      flag,
   output logic                      blk_hit
);
   logic [ADDR_W-1:BLK_LSB] blk_q;

   assign blk_hit = flag && (blk_q == cmp_blk);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         blk_q <= '0;
      end else if (set_en) begin
         flag  <= 1'b1;
         blk_q <= cmp_blk;
      end else if (fail_clr || (kill_en && blk_hit)) begin
         flag  <= 1'b0;
      end
   end

   assert_lock_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> (flag && blk_q == $past(cmp_blk)));
   assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_en && blk_hit && !set_en) |=> !flag);
   assert_fail_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_clr && !set_en) |=> !flag);
endmodule

// File: rtl/resv_fail_track.sv
module resv_fail_track #(
   parameter int WARN_EVERY = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic clr,
   output logic wrap
);
   localparam int PH_W = $clog2(WARN_EVERY + 1);
   localparam logic [PH_W-1:0] LAST = PH_W'(WARN_EVERY - 1);

   logic [PH_W-1:0] phase_q;

   assign wrap = inc && (phase_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)       phase_q <= '0;
      else if (wrap)           phase_q <= '0;
      else if (inc)            phase_q <= phase_q + 1'b1;
   end

   assert_success_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (phase_q == '0));
   assert_phase_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= LAST);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int N_CTX      = 4,
   parameter int ADDR_W     = 32,
   parameter int BLK_LSB    = 4,
   parameter int WARN_EVERY = 100000,
   localparam int CTX_W     = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [1:0]        req_kind,
   input  logic              req_uncached,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              sc_done,
   output logic              sc_success,
   output logic              wr_permit,
   output logic              warn_pulse,
   output logic [CTX_W-1:0]  warn_ctx
);
   if (N_CTX < 1)            begin : g_bad_ctx   $error("N_CTX must be at least 1");        end
   if (WARN_EVERY < 1)       begin : g_bad_warn  $error("WARN_EVERY must be at least 1");   end
   if (BLK_LSB >= ADDR_W)    begin : g_bad_blk   $error("BLK_LSB must be below ADDR_W");    end
   if (BLK_LSB < 1)          begin : g_bad_lsb   $error("BLK_LSB must be at least 1");      end

   req_kind_e              kind;
   logic [N_CTX-1:0]       flag_vec, hit_vec, wrap_vec;
   logic [N_CTX-1:0]       sel;
   logic                   own_hit, is_cs, cs_ok, cs_fail, kill;
   logic                   unused_lo;

   assign kind      = req_kind_e'(req_kind);
   assign unused_lo = ^req_addr[BLK_LSB-1:0];

   always_comb begin
      sel = '0;
      for (int i = 0; i < N_CTX; i++)
         sel[i] = (req_ctx == CTX_W'(i));
   end

   assign own_hit = |(hit_vec & sel);
   assign is_cs   = req_valid && (kind == K_COND_STORE);
   assign cs_ok   = is_cs && (req_uncached || own_hit);
   assign cs_fail = is_cs && !req_uncached && !own_hit;
   assign kill    = (req_valid && kind == K_STORE) || cs_ok;

   for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
      resv_slot #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_en   (req_valid && kind == K_LOCK_LOAD && sel[g]),
         .fail_clr (cs_fail && sel[g]),
         .kill_en  (kill),
         .cmp_blk  (req_addr[ADDR_W-1:BLK_LSB]),
         .flag     (flag_vec[g]),
         .blk_hit  (hit_vec[g])
      );
      resv_fail_track #(.WARN_EVERY(WARN_EVERY)) u_track (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (cs_fail && sel[g]),
         .clr   (cs_ok && sel[g]),
         .wrap  (wrap_vec[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_done    <= 1'b0;
         sc_success <= 1'b0;
         wr_permit  <= 1'b0;
         warn_pulse <= 1'b0;
         warn_ctx   <= '0;
      end else begin
         sc_done    <= is_cs;
         sc_success <= cs_ok;
         wr_permit  <= kill;
         warn_pulse <= |wrap_vec;
         warn_ctx   <= |wrap_vec ? req_ctx : '0;
      end
   end

   assert_fail_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_done && !sc_success) |-> !wr_permit);
   assert_warn_on_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      warn_pulse |-> (sc_done && !sc_success));
   assert_uncached_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == K_COND_STORE && req_uncached) |=> (sc_done && sc_success));
   assert_load_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && kind == K_LOAD) |=> ($stable(flag_vec) && !wr_permit && !sc_done));
   assert_success_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sc_success |-> sc_done);
endmodule

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
   localparam int N = 4;
   localparam int AW = 32;
   localparam int CW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [CW-1:0] req_ctx = '0;
   logic [1:0] req_kind = '0;
   logic req_uncached = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic sc_done, sc_success, wr_permit, warn_pulse;
   logic [CW-1:0] warn_ctx;

   int n_run = 0;
   int n_fail = 0;
   bit pend = 1'b0;

   typedef struct {
      logic done, ok, wr, warn;
      logic [CW-1:0] wctx;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;   // 250 MHz

   resv_monitor #(.N_CTX(N), .ADDR_W(AW), .BLK_LSB(4), .WARN_EVERY(3)) u_resv_monitor (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctx(req_ctx),
      .req_kind(req_kind), .req_uncached(req_uncached), .req_addr(req_addr),
      .sc_done(sc_done), .sc_success(sc_success), .wr_permit(wr_permit),
      .warn_pulse(warn_pulse), .warn_ctx(warn_ctx));

   always @(posedge clk) pend <= req_valid;

   // monitor: compares the registered outputs of the previous request
   always @(negedge clk) begin
      if (pend && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_run++;
         if ({sc_done, sc_success, wr_permit, warn_pulse} != {e.done, e.ok, e.wr, e.warn} ||
             (e.warn && warn_ctx != e.wctx)) begin
            n_fail++;
            $display("FAIL %s: got done=%b ok=%b wr=%b warn=%b ctx=%0d, exp done=%b ok=%b wr=%b warn=%b ctx=%0d",
                     e.tag, sc_done, sc_success, wr_permit, warn_pulse, warn_ctx,
                     e.done, e.ok, e.wr, e.warn, e.wctx);
         end
      end
   end

   task automatic issue(input int ctx, input int kind, input bit unc, input logic [AW-1:0] a,
                        input bit d, input bit ok, input bit wr, input bit wn, input int wc,
                        input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_ctx = CW'(ctx); req_kind = 2'(kind);
      req_uncached = unc; req_addr = a;
      e.done = d; e.ok = ok; e.wr = wr; e.warn = wn; e.wctx = CW'(wc); e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #40000;
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      n_run++;   // R11: outputs clear out of reset
      if ({sc_done, sc_success, wr_permit, warn_pulse} != 4'b0) begin
         n_fail++;
         $display("FAIL R11 reset outputs: got %b exp 0000", {sc_done, sc_success, wr_permit, warn_pulse});
      end
      // kinds: 0 load, 1 locked load, 2 store, 3 conditional store
      issue(0, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R11 R3 no flag after reset");
      issue(0, 1, 0, 32'h100, 0, 0, 0, 0, 0, "R9 locked load no write");
      issue(0, 3, 0, 32'h108, 1, 1, 1, 0, 0, "R1 R2 R12 success low bits ignored");
      issue(0, 3, 0, 32'h100, 1, 0, 0, 0, 0, "R8 own reservation consumed");
      issue(1, 1, 0, 32'h200, 0, 0, 0, 0, 0, "R1 lock c1");
      issue(2, 1, 0, 32'h20C, 0, 0, 0, 0, 0, "R1 lock c2");
      issue(3, 1, 0, 32'h300, 0, 0, 0, 0, 0, "R1 lock c3");
      issue(0, 0, 0, 32'h200, 0, 0, 0, 0, 0, "R10 R9 plain load quiet");
      issue(1, 3, 0, 32'h204, 1, 1, 1, 0, 0, "R10 R2 c1 success after load");
      issue(2, 3, 0, 32'h200, 1, 0, 0, 0, 0, "R8 cross-context kill c2");
      issue(2, 1, 0, 32'h400, 0, 0, 0, 0, 0, "R1 relock c2");
      issue(2, 3, 0, 32'h410, 1, 0, 0, 0, 0, "R4 block mismatch");
      issue(2, 3, 0, 32'h400, 1, 0, 0, 1, 2, "R4 R5 flag cleared, warn c2");
      idle();
      issue(0, 1, 0, 32'h500, 0, 0, 0, 0, 0, "R1 lock c0");
      issue(0, 3, 0, 32'h500, 1, 1, 1, 0, 0, "R6 success resets count");
      issue(0, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R6 fail 1 no warn");
      issue(0, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R6 fail 2 no warn");
      issue(0, 3, 0, 32'h000, 1, 0, 0, 1, 0, "R5 fail 3 warn c0");
      issue(1, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R3 c1 fail 1");
      issue(1, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R3 c1 fail 2");
      issue(1, 3, 1, 32'h300, 1, 1, 1, 0, 0, "R7 uncached success");
      issue(3, 3, 0, 32'h300, 1, 0, 0, 0, 0, "R8 uncached kills c3");
      issue(1, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R7 count reset fail 1");
      issue(1, 3, 0, 32'h000, 1, 0, 0, 0, 0, "R7 count reset fail 2");
      issue(1, 3, 0, 32'h000, 1, 0, 0, 1, 1, "R5 R7 fail 3 warn c1");
      issue(0, 1, 0, 32'h600, 0, 0, 0, 0, 0, "R1 lock c0 600");
      issue(3, 2, 0, 32'h60F, 0, 0, 1, 0, 0, "R9 plain store writes");
      issue(0, 3, 0, 32'h600, 1, 0, 0, 0, 0, "R8 plain store kills");
      issue(1, 1, 0, 32'h700, 0, 0, 0, 0, 0, "R1 lock c1 700");
      issue(1, 0, 0, 32'h700, 0, 0, 0, 0, 0, "R10 load same block");
      issue(1, 3, 0, 32'h70C, 1, 1, 1, 0, 0, "R10 reservation kept");
      idle();
      idle();
      idle();
      n_run++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R12 scoreboard drain: got %0d left exp 0", sb.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule